// File: doc/BRIEF.md
# Windowed Saturating Error Counter

This block counts error events from one of three upstream sources and shows the total as a 16-bit value. A host reads that value one byte at a time. The three sources are single-bit corrections from the inner decoder, byte corrections from the block decoder, and packets that could not be corrected. A two-bit select chooses which source feeds the counter.

The block has two modes. In windowed mode it measures an error rate. A window timer counts valid output bytes. When the window closes, the running count is copied into a holding register and the counter restarts, so the visible value is the count from the last complete window. In free-running mode the visible value follows the live counter, and a host read of the high byte clears the counter. In both modes the counter stops at 0xFFFF instead of wrapping.

A host can do a 16-bit access by reading the high byte and then, on the very next cycle, the low byte. The low byte is latched at the moment the high byte is read, so the two halves always belong to the same value, even when the high-byte read clears the counter. A host can also read either byte on its own.

Top module: `err_window_counter`

## Requirements
- R1: After synchronous reset, the visible value is 0, the window timer is at 0, and the read byte is 0.
- R2: The source select works as follows: 0 counts bit corrections, 1 counts byte corrections, 2 counts uncorrectable packets, and 3 counts nothing. Pulses on sources that are not selected have no effect on the count.
- R3: In windowed mode (mode bit 0), the visible value is the holding register. When the valid byte that closes a window arrives, the count so far is copied into the holding register and the counter is cleared.
- R4: The window length is 2^(B + 2·k) valid bytes, where k is the window select (0 to 3) and B is a parameter with a default of 12. Cycles without a byte-valid strobe do not advance the window.
- R5: An error that arrives in the same cycle as a window rollover, or in the same cycle as a clearing read, is counted into the new period and not into the old one.
- R6: In free-running mode (mode bit 1), the visible value equals the live counter. It shows each counted event one cycle after that event.
- R7: In free-running mode, a high-byte read clears the counter in that cycle.
- R8: In both modes, the counter stays at 0xFFFF once it gets there, until it is cleared.
- R9: While the high-byte strobe is active, the read byte is bits 15:8 of the visible value. The high-byte strobe wins if both strobes are active. A low-byte strobe alone returns bits 7:0. With no strobe active, the read byte is 0.
- R10: A low-byte strobe in the cycle right after a high-byte strobe returns bits 7:0 as they were on the high-byte cycle.
- R11: In windowed mode, a high-byte read does not change the counter or the holding register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_bit_i | input | 1 | Bit-correction event pulse |
| err_byte_i | input | 1 | Byte-correction event pulse |
| err_pkt_i | input | 1 | Uncorrectable-packet event pulse |
| byte_vld_i | input | 1 | One valid output byte this cycle |
| src_sel_i | input | 2 | Counted source select (0 bit, 1 byte, 2 packet, 3 none) |
| mode_i | input | 1 | 0 windowed rate, 1 free-running |
| win_sel_i | input | 2 | Window length select |
| rd_hi_i | input | 1 | Host read strobe, high byte |
| rd_lo_i | input | 1 | Host read strobe, low byte |
| view_o | output | 16 | Visible 16-bit value |
| rd_byte_o | output | 8 | Byte returned to the host for the active strobe |

## Verification
The bench puts an error on the exact byte that closes a window and on the exact cycle of a clearing high-byte read. A design that credits the old period would report a window total one too high, or would lose the event after a clear. It reads the two halves of a free-running count while the high read clears it. A design without the low-byte latch would return 0 instead of the pre-clear low byte. It also runs the count past 65535, where a wrapping counter would fall back to small values. Finally, it sweeps all four window lengths, which exposes an off-by-one in the rollover compare.

// File: rtl/errmon_pkg.sv
package errmon_pkg;

    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int NUM_WIN = 4;

    typedef enum logic [1:0] {
        SRC_BIT  = 2'd0,
        SRC_BYTE = 2'd1,
        SRC_PKT  = 2'd2,
        SRC_NONE = 2'd3
    } err_src_e;

    typedef enum logic {
        MODE_WINDOW = 1'b0,
        MODE_FREE   = 1'b1
    } cnt_mode_e;

    typedef struct packed {
        logic bit_err;
        logic byte_err;
        logic pkt_err;
    } err_events_t;

    typedef struct packed {
        logic inc;
        logic clr;
        logic snap;
    } cnt_ctrl_t;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == {CNT_W{1'b1}}) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/err_src_mux.sv
module err_src_mux
    import errmon_pkg::*;
(
    input  err_events_t events_i,
    input  err_src_e    sel_i,
    output logic        event_o
);
    always_comb begin
        unique case (sel_i)
            SRC_BIT:  event_o = events_i.bit_err;
            SRC_BYTE: event_o = events_i.byte_err;
            SRC_PKT:  event_o = events_i.pkt_err;
            default:  event_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/err_window_timer.sv
module err_window_timer
    import errmon_pkg::*;
#(
    parameter int BASE_LOG2 = 12,
    parameter int STEP_LOG2 = 2,
    parameter int W         = BASE_LOG2 + (NUM_WIN - 1) * STEP_LOG2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable_i,
    input  logic       byte_vld_i,
    input  logic [1:0] win_sel_i,
    output logic       tick_o
);
    logic [W-1:0] limit [NUM_WIN];
    logic [W-1:0] cnt_q;

    // Last byte index of each window: 2^(BASE + g*STEP) - 1
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_limit
        localparam int LOG_G = BASE_LOG2 + g * STEP_LOG2;
        assign limit[g] = W'((64'd1 << LOG_G) - 64'd1);
    end

    // >= keeps a shrunken window from running past its end
    assign tick_o = enable_i && byte_vld_i && (cnt_q >= limit[win_sel_i]);

    always_ff @(posedge clk) begin
        if (rst || !enable_i) begin
            cnt_q <= '0;
        end else if (byte_vld_i) begin
            cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/err_sat_counter.sv
module err_sat_counter
    import errmon_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cnt_mode_e        mode_i,
    input  logic             event_i,
    input  logic             tick_i,
    input  logic             rd_hi_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] hold_o
);
    cnt_ctrl_t        ctrl;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] hold_q;

    always_comb begin
        ctrl.inc  = event_i;
        ctrl.snap = (mode_i == MODE_WINDOW) && tick_i;
        ctrl.clr  = (mode_i == MODE_FREE) ? rd_hi_i : tick_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            hold_q <= '0;
        end else begin
            if (ctrl.snap) begin
                hold_q <= cnt_q;
            end
            // Coinciding event starts the new period at one
            if (ctrl.clr) begin
                cnt_q <= ctrl.inc ? CNT_W'(1) : '0;
            end else if (ctrl.inc) begin
                cnt_q <= sat_inc(cnt_q);
            end
        end
    end

    assign cnt_o  = cnt_q;
    assign hold_o = hold_q;
endmodule

// File: rtl/err_read_port.sv
module err_read_port
    import errmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  view_i,
    input  logic              rd_hi_i,
    input  logic              rd_lo_i,
    output logic [BYTE_W-1:0] rd_byte_o
);
    logic [BYTE_W-1:0] lo_latch_q;
    logic              lo_pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_latch_q <= '0;
            lo_pend_q  <= 1'b0;
        end else begin
            lo_pend_q <= rd_hi_i;
            if (rd_hi_i) begin
                lo_latch_q <= view_i[BYTE_W-1:0];
            end
        end
    end

    always_comb begin
        if (rd_hi_i) begin
            rd_byte_o = view_i[CNT_W-1:BYTE_W];
        end else if (rd_lo_i) begin
            rd_byte_o = lo_pend_q ? lo_latch_q : view_i[BYTE_W-1:0];
        end else begin
            rd_byte_o = '0;
        end
    end
endmodule

// File: rtl/err_window_counter.sv
module err_window_counter
    import errmon_pkg::*;
#(
    parameter int WIN_BASE_LOG2 = 12,
    parameter int WIN_STEP_LOG2 = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        err_bit_i,
    input  logic        err_byte_i,
    input  logic        err_pkt_i,
    input  logic        byte_vld_i,
    input  logic [1:0]  src_sel_i,
    input  logic        mode_i,
    input  logic [1:0]  win_sel_i,
    input  logic        rd_hi_i,
    input  logic        rd_lo_i,
    output logic [15:0] view_o,
    output logic [7:0]  rd_byte_o
);
    localparam int WIN_W = WIN_BASE_LOG2 + (NUM_WIN - 1) * WIN_STEP_LOG2;

    err_events_t      events;
    cnt_mode_e        mode;
    logic             sel_event;
    logic             win_tick;
    logic [CNT_W-1:0] live_cnt;
    logic [CNT_W-1:0] hold_cnt;

    assign events = '{bit_err: err_bit_i, byte_err: err_byte_i, pkt_err: err_pkt_i};
    assign mode   = cnt_mode_e'(mode_i);

    err_src_mux u_mux (
        .events_i (events),
        .sel_i    (err_src_e'(src_sel_i)),
        .event_o  (sel_event)
    );

    err_window_timer #(
        .BASE_LOG2 (WIN_BASE_LOG2),
        .STEP_LOG2 (WIN_STEP_LOG2),
        .W         (WIN_W)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .enable_i   (mode == MODE_WINDOW),
        .byte_vld_i (byte_vld_i),
        .win_sel_i  (win_sel_i),
        .tick_o     (win_tick)
    );

    err_sat_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .mode_i  (mode),
        .event_i (sel_event),
        .tick_i  (win_tick),
        .rd_hi_i (rd_hi_i),
        .cnt_o   (live_cnt),
        .hold_o  (hold_cnt)
    );

    assign view_o = (mode == MODE_FREE) ? live_cnt : hold_cnt;

    err_read_port u_rd (
        .clk       (clk),
        .rst       (rst),
        .view_i    (view_o),
        .rd_hi_i   (rd_hi_i),
        .rd_lo_i   (rd_lo_i),
        .rd_byte_o (rd_byte_o)
    );
endmodule

// File: rtl/err_window_counter_chk.sv
module err_window_counter_chk (
    input logic        clk,
    input logic        rst,
    input logic        mode_i,
    input logic        rd_hi_i,
    input logic        rd_lo_i,
    input logic        byte_vld_i,
    input logic [1:0]  src_sel_i,
    input logic [15:0] view_o,
    input logic [7:0]  rd_byte_o
);
    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_i && view_o == 16'hFFFF && !rd_hi_i) |=> (!mode_i || view_o == 16'hFFFF));

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_i && rd_hi_i) |=> (!mode_i || view_o <= 16'd1));

    assert_step_one_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_i && !rd_hi_i) |=> (!mode_i || (view_o - $past(view_o)) <= 16'd1));

    assert_window_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!mode_i && !byte_vld_i) |=> (mode_i || $stable(view_o)));

    assert_none_source_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_i && src_sel_i == 2'd3 && !rd_hi_i) |=> (!mode_i || $stable(view_o)));

    assert_pair_latch_R10: assert property (@(posedge clk) disable iff (rst)
        rd_hi_i |=> ((!rd_lo_i || rd_hi_i) || rd_byte_o == $past(view_o[7:0])));
endmodule

bind err_window_counter err_window_counter_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode_i),
    .rd_hi_i    (rd_hi_i),
    .rd_lo_i    (rd_lo_i),
    .byte_vld_i (byte_vld_i),
    .src_sel_i  (src_sel_i),
    .view_o     (view_o),
    .rd_byte_o  (rd_byte_o)
);

// File: tb/err_window_counter_tb.sv
module err_window_counter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BASE = 4;
    localparam int STEP = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        err_bit = 0, err_byte = 0, err_pkt = 0, byte_vld = 0;
    logic [1:0]  src_sel = 0, win_sel = 0;
    logic        mode = 0, rd_hi = 0, rd_lo = 0;
    logic [15:0] view;
    logic [7:0]  rd_byte;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    err_window_counter #(.WIN_BASE_LOG2(BASE), .WIN_STEP_LOG2(STEP)) u_dut (
        .clk(clk), .rst(rst), .err_bit_i(err_bit), .err_byte_i(err_byte),
        .err_pkt_i(err_pkt), .byte_vld_i(byte_vld), .src_sel_i(src_sel),
        .mode_i(mode), .win_sel_i(win_sel), .rd_hi_i(rd_hi), .rd_lo_i(rd_lo),
        .view_o(view), .rd_byte_o(rd_byte)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    // Entered at a falling edge; applies inputs across one rising edge.
    task automatic cyc(input logic eb, input logic ey, input logic ep,
                       input logic bv, input logic rh, input logic rl);
        err_bit = eb; err_byte = ey; err_pkt = ep;
        byte_vld = bv; rd_hi = rh; rd_lo = rl;
        @(posedge clk);
        @(negedge clk);
        err_bit = 0; err_byte = 0; err_pkt = 0;
        byte_vld = 0; rd_hi = 0; rd_lo = 0;
    endtask

    task automatic do_reset();
        rst = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;
    endtask

    task automatic t_reset();
        mode = 1; src_sel = 0;
        do_reset();
        check("R1 view", view, 0);
        check("R1 byte idle", rd_byte, 0);
        mode = 0;
        check("R1 hold", view, 0);
    endtask

    task automatic t_sources();
        mode = 1;
        for (int s = 0; s < 4; s++) begin
            src_sel = s[1:0];
            do_reset();
            for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, 0);
            for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0, 0, 0);
            for (int i = 0; i < 7; i++) cyc(0, 0, 1, 0, 0, 0);
            check("R2 source", view, (s == 0) ? 3 : (s == 1) ? 5 : (s == 2) ? 7 : 0);
        end
        src_sel = 0;
        do_reset();
        cyc(1, 0, 0, 0, 0, 0);
        check("R6 one cycle", view, 1);
    endtask

    task automatic t_reads();
        mode = 1; src_sel = 0;
        do_reset();
        for (int i = 0; i < 291; i++) cyc(1, 0, 0, 0, 0, 0);
        check("R6 live", view, 16'h0123);
        rd_lo = 1; #1;
        check("R9 lo alone", rd_byte, 8'h23);
        rd_hi = 1; #1;
        check("R9 hi wins", rd_byte, 8'h01);
        rd_lo = 0;
        cyc(0, 0, 0, 0, 1, 0);
        check("R7 cleared", view, 0);
        rd_lo = 1; #1;
        check("R10 latched lo", rd_byte, 8'h23);
        rd_lo = 0; #1;
        check("R9 idle", rd_byte, 0);
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 1, 0);
        check("R5 R7 event on clear", view, 1);
    endtask

    task automatic t_window();
        int len;
        mode = 0; src_sel = 2; win_sel = 0;
        do_reset();
        for (int i = 0; i < 5; i++) cyc(0, 0, 1, 1, 0, 0);
        for (int i = 0; i < 10; i++) cyc(0, 0, 0, (i != 3), 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        check("R3 before close", view, 0);
        cyc(0, 0, 0, 1, 0, 0);
        check("R3 snapshot", view, 5);
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 1, 0, 0);
        cyc(0, 0, 0, 1, 1, 0);
        check("R11 hold kept", view, 5);
        for (int i = 0; i < 12; i++) cyc(0, 0, 0, 1, 0, 0);
        check("R11 no clear", view, 3);
        for (int i = 0; i < 15; i++) cyc(0, 0, 0, 1, 0, 0);
        cyc(0, 0, 1, 1, 0, 0);
        check("R5 rollover event excluded", view, 0);
        for (int i = 0; i < 16; i++) cyc(0, 0, 0, 1, 0, 0);
        check("R5 rollover event carried", view, 1);
        for (int w = 1; w < 4; w++) begin
            win_sel = w[1:0];
            len = 1 << (BASE + w * STEP);
            do_reset();
            for (int i = 0; i < len - 1; i++) cyc(0, 0, 1, 1, 0, 0);
            check("R4 open window", view, 0);
            cyc(0, 0, 1, 1, 0, 0);
            check("R4 window length", view, len - 1);
        end
        win_sel = 0;
    endtask

    task automatic t_saturate();
        mode = 1; src_sel = 1;
        do_reset();
        for (int i = 0; i < 65540; i++) cyc(0, 1, 0, 0, 0, 0);
        check("R8 saturated", view, 16'hFFFF);
        cyc(0, 0, 0, 0, 1, 0);
        check("R8 clear after sat", view, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_sources();
        t_reads();
        t_window();
        t_saturate();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule